// File: doc/BRIEF.md
# HDLC Frame Transmitter with Command-Driven FIFO

This block turns bytes loaded by a host into a bit-serial HDLC stream. The host writes bytes into a 32-entry transmit FIFO. A one-cycle start command opens a frame. A one-cycle message-end command tells the block that the final bytes are already queued. The transmitter sends an opening flag, then the bytes least significant bit first with zero insertion, then a 16-bit frame check sequence, then a closing flag.

The line side advances one bit for each `bit_tick_i` pulse. Between frames the line carries either continuous flags or all ones, chosen by a mode input. Three status outputs are provided: FIFO write-enable, a sticky overflow flag and a sticky underrun flag. A level-sensitive transmitter reset command empties the FIFO, cancels pending commands and aborts any frame on the line.

Top module: `hdlc_tx_engine`

## Requirements
- R1: The FIFO holds 32 bytes. `wr_ok_o` is 1 while fewer than 32 bytes are stored and 0 when 32 bytes are stored.
- R2: A write while the FIFO is full and no byte leaves in that cycle is discarded and sets `ovf_o`. `ovf_o` stays set until a reset command clears it.
- R3: After a start pulse, at the next fill-unit boundary, the block sends an opening flag 0x7E, least significant bit first (bits 0,1,1,1,1,1,1,0).
- R4: Frame bytes are sent least significant bit first, in write order. Inside the data and check-sequence fields, a 0 is inserted after every five consecutive 1s, including after the last check bit.
- R5: After the last byte, when message-end has been given, the block sends the CRC-16: polynomial x^16+x^12+x^5+1, bit-reflected, initial value 0xFFFF, output complemented. The low byte goes first and each byte goes least significant bit first. A closing flag 0x7E follows. A frame with no bytes carries only the check sequence 0x0000.
- R6: Between frames, `fill_flags_i`=1 sends repeated 0x7E and `fill_flags_i`=0 sends continuous 1s.
- R7: If the FIFO is empty at a byte boundary and message-end has not been given, the frame ends with seven 1s with no zero insertion, the fill resumes, and the sticky `urun_o` is set.
- R8: While `cmd_reset_i` is 1, the FIFO is emptied and a write in that cycle is discarded. Pending start and end commands and both sticky flags are cleared. A frame in progress is replaced at once by seven 1s followed by fill.
- R9: `txd_stb_o` is 1 exactly in the cycle after each cycle with `bit_tick_i`=1, and `txd_o` then holds the new line bit.
- R10: Start and end commands clear themselves. One start pulse produces exactly one frame, after which the fill continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one byte into the FIFO |
| wr_data_i | input | 8 | Byte to write |
| cmd_start_i | input | 1 | One-cycle start-frame command |
| cmd_end_i | input | 1 | One-cycle message-end command |
| cmd_reset_i | input | 1 | Level transmitter reset command |
| fill_flags_i | input | 1 | Interframe fill: 1 = flags, 0 = ones |
| bit_tick_i | input | 1 | Advance the line by one bit |
| txd_o | output | 1 | Serial line bit |
| txd_stb_o | output | 1 | Strobe marking a new line bit |
| wr_ok_o | output | 1 | FIFO can accept a byte |
| ovf_o | output | 1 | Sticky FIFO overflow |
| urun_o | output | 1 | Sticky frame underrun |

## Verification
A host write and a transmitter reset command can fall in the same cycle. The bench provokes this by holding a write on `wr_en_i` in the very cycle that raises `cmd_reset_i` in the middle of a frame. The result is judged at the ports. The line must show only 1s from the next bit onward, and both status flags must read clear. A later frame with message-end and start but no new writes must carry only the empty-frame check sequence. This proves that the colliding byte never reached the FIFO.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam logic [7:0]  FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_FILL, ST_OPEN, ST_DATA, ST_CRC, ST_CLOSE, ST_ABORT
  } tx_state_e;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_POLY_R : 16'h0000);
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign rdata_o = mem_q[rp_q];
  assign ovf_o   = ovf_q;
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : AW'(p + 1'b1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; ovf_q <= 1'b0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (do_push) wp_q <= inc(wp_q);
      if (do_pop)  rp_q <= inc(rp_q);
      if (do_push && !do_pop) cnt_q <= CW'(cnt_q + 1'b1);
      else if (do_pop && !do_push) cnt_q <= CW'(cnt_q - 1'b1);
      if (push_i && full_o && !do_pop) ovf_q <= 1'b1;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_pop_nonempty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_ovf_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(push_i && full_o));
endmodule

// File: rtl/hdlc_crc16.sv
module hdlc_crc16
  import hdlc_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        upd_i,
  input  logic        bit_i,
  output logic [15:0] crc_o,
  output logic [15:0] crc_nx_o
);
  logic [15:0] crc_q;

  assign crc_o    = crc_q;
  assign crc_nx_o = crc_step(crc_q, bit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (init_i) crc_q <= CRC_SEED;
    else if (upd_i)  crc_q <= crc_nx_o;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        fill_flags_i,
  input  logic        start_i,
  input  logic        end_i,
  input  logic        abort_i,
  input  logic        empty_i,
  input  logic [7:0]  rdata_i,
  output logic        pop_o,
  input  logic [15:0] crc_i,
  input  logic [15:0] crc_nx_i,
  output logic        crc_init_o,
  output logic        crc_upd_o,
  output logic        crc_bit_o,
  output logic        txd_o,
  output logic        stb_o,
  output logic        urun_o
);
  tx_state_e   st_q;
  logic [15:0] sh_q;
  logic [3:0]  cnt_q;
  logic [2:0]  ones_q;
  logic        start_q, end_q, urun_q, txd_q, stb_q;
  logic        stuff, cur_bit, unit_end, in_frame, ab;

  assign in_frame = (st_q == ST_OPEN) || (st_q == ST_DATA) ||
                    (st_q == ST_CRC)  || (st_q == ST_CLOSE);
  assign ab       = abort_i && in_frame;
  assign stuff    = (ones_q == 3'd5);

  always_comb begin
    if (stuff)                                                cur_bit = 1'b0;
    else if (st_q == ST_ABORT || (st_q == ST_FILL && !fill_flags_i)) cur_bit = 1'b1;
    else                                                      cur_bit = sh_q[0];
    unique case (st_q)
      ST_FILL:  unit_end = fill_flags_i ? (cnt_q == 4'd7) : 1'b1;
      ST_CRC:   unit_end = (cnt_q == 4'd15);
      ST_ABORT: unit_end = (cnt_q == 4'd6);
      default:  unit_end = (cnt_q == 4'd7);
    endcase
  end

  assign pop_o      = tick_i && !ab && !stuff && unit_end && !empty_i &&
                      (st_q == ST_OPEN || st_q == ST_DATA);
  assign crc_init_o = (st_q == ST_OPEN);
  assign crc_upd_o  = tick_i && !ab && !stuff && (st_q == ST_DATA);
  assign crc_bit_o  = sh_q[0];
  assign txd_o      = txd_q;
  assign stb_o      = stb_q;
  assign urun_o     = urun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_FILL; sh_q <= 16'(FLAG_BYTE); cnt_q <= '0; ones_q <= '0;
      start_q <= 1'b0; end_q <= 1'b0; urun_q <= 1'b0; txd_q <= 1'b1; stb_q <= 1'b0;
    end else begin
      stb_q <= tick_i;
      if (start_i) start_q <= 1'b1;
      if (end_i)   end_q   <= 1'b1;
      if (abort_i) begin
        start_q <= 1'b0; end_q <= 1'b0; urun_q <= 1'b0;
      end
      if (ab) begin
        st_q <= ST_ABORT; ones_q <= '0;
        cnt_q <= tick_i ? 4'd1 : 4'd0;
        if (tick_i) txd_q <= 1'b1;
      end else if (tick_i) begin
        txd_q <= cur_bit;
        if (stuff) begin
          ones_q <= '0;
        end else begin
          sh_q   <= sh_q >> 1;
          cnt_q  <= 4'(cnt_q + 1'b1);
          ones_q <= (st_q == ST_DATA || st_q == ST_CRC) ?
                    (cur_bit ? 3'(ones_q + 1'b1) : 3'd0) : 3'd0;
          if (unit_end) begin
            cnt_q <= '0;
            unique case (st_q)
              ST_FILL: begin
                sh_q <= 16'(FLAG_BYTE);
                if (start_q && !abort_i) begin
                  st_q <= ST_OPEN; start_q <= 1'b0;
                end
              end
              ST_OPEN, ST_DATA: begin
                if (!empty_i) begin
                  st_q <= ST_DATA; sh_q <= 16'(rdata_i);
                end else if (end_q) begin
                  st_q <= ST_CRC;
                  sh_q <= ~((st_q == ST_DATA) ? crc_nx_i : crc_i);
                end else begin
                  st_q <= ST_ABORT; ones_q <= '0; urun_q <= 1'b1;
                end
              end
              ST_CRC: begin
                st_q <= ST_CLOSE; sh_q <= 16'(FLAG_BYTE); end_q <= 1'b0;
              end
              default: begin
                st_q <= ST_FILL; sh_q <= 16'(FLAG_BYTE);
              end
            endcase
          end
        end
      end
    end
  end

  assert_stuff_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && stuff && !ab) |=> !txd_q);
  assert_abort_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && st_q == ST_ABORT) |=> txd_q);
  assert_urun_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(urun_q) |-> st_q == ST_ABORT);
  assert_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> stb_q);
  assert_reset_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && in_frame) |=> st_q == ST_ABORT);
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          cmd_start_i,
  input  logic          cmd_end_i,
  input  logic          cmd_reset_i,
  input  logic          fill_flags_i,
  input  logic          bit_tick_i,
  output logic          txd_o,
  output logic          txd_stb_o,
  output logic          wr_ok_o,
  output logic          ovf_o,
  output logic          urun_o
);
  logic [DW-1:0] rdata;
  logic          empty, full, pop;
  logic [15:0]   crc, crc_nx;
  logic          crc_init, crc_upd, crc_bit;

  assign wr_ok_o = !full;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(cmd_reset_i),
    .push_i(wr_en_i), .wdata_i(wr_data_i), .pop_i(pop),
    .rdata_o(rdata), .empty_o(empty), .full_o(full), .ovf_o(ovf_o)
  );

  hdlc_crc16 u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(crc_init), .upd_i(crc_upd),
    .bit_i(crc_bit), .crc_o(crc), .crc_nx_o(crc_nx)
  );

  hdlc_tx_framer u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(bit_tick_i),
    .fill_flags_i(fill_flags_i), .start_i(cmd_start_i), .end_i(cmd_end_i),
    .abort_i(cmd_reset_i), .empty_i(empty), .rdata_i(rdata[7:0]), .pop_o(pop),
    .crc_i(crc), .crc_nx_i(crc_nx), .crc_init_o(crc_init), .crc_upd_o(crc_upd),
    .crc_bit_o(crc_bit), .txd_o(txd_o), .stb_o(txd_stb_o), .urun_o(urun_o)
  );

  assert_full_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !pop && !cmd_reset_i) |=> !wr_ok_o);
endmodule

// File: tb/sim_hdlc_tx_engine.sv
module sim_hdlc_tx_engine;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cmd_start = 1'b0, cmd_end = 1'b0, cmd_rst = 1'b0;
  logic fill_flags = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, txd_stb, wr_ok, ovf, urun;

  int n_cmp = 0, n_bad = 0;
  bit exp_q[$];
  bit cmp_on = 0;
  bit done = 0;
  string cur_tag = "R4";

  hdlc_tx_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cmd_start_i(cmd_start), .cmd_end_i(cmd_end), .cmd_reset_i(cmd_rst),
    .fill_flags_i(fill_flags), .bit_tick_i(tick), .txd_o(txd),
    .txd_stb_o(txd_stb), .wr_ok_o(wr_ok), .ovf_o(ovf), .urun_o(urun)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk); #1;
      tick = ~tick;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: hunt for the opening 0, then pop and compare each line bit
  always @(negedge clk) begin
    if (rst_n && txd_stb) begin
      if (cmp_on) begin
        bit e;
        e = exp_q.pop_front();
        chk(txd == e, cur_tag, int'(txd), int'(e));
        if (exp_q.size() == 0) cmp_on = 0;
      end else if (exp_q.size() > 0 && txd == 1'b0) begin
        bit e;
        e = exp_q.pop_front();
        chk(txd == e, cur_tag, int'(txd), int'(e));
        cmp_on = (exp_q.size() > 0);
      end
    end
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input bit b);
    logic [15:0] r;
    r = {1'b0, c[15:1]};
    if (c[0] ^ b) r = r ^ 16'h8408;
    return r;
  endfunction

  task automatic push_frame(input logic [7:0] d[$], input bit good);
    logic [15:0] c;
    bit body[$];
    int ones;
    c = 16'hFFFF;
    foreach (d[k]) for (int i = 0; i < 8; i++) begin
      body.push_back(d[k][i]);
      c = ref_crc(c, d[k][i]);
    end
    if (good) begin
      c = ~c;
      for (int i = 0; i < 16; i++) body.push_back(c[i]);
    end
    for (int i = 0; i < 8; i++) exp_q.push_back(8'h7E >> i);
    ones = 0;
    foreach (body[j]) begin
      exp_q.push_back(body[j]);
      ones = body[j] ? ones + 1 : 0;
      if (ones == 5 && (good || j < body.size() - 1)) begin
        exp_q.push_back(1'b0);
        ones = 0;
      end
    end
    if (good) for (int i = 0; i < 8; i++) exp_q.push_back(8'h7E >> i);
    else      for (int i = 0; i < 7; i++) exp_q.push_back(1'b1);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; cmd_start = 1'b1;
    @(posedge clk); #1; cmd_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(posedge clk); #1; cmd_end = 1'b1;
    @(posedge clk); #1; cmd_end = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    do @(negedge clk); while (!txd_stb);
    b = txd;
  endtask

  task automatic wait_frame(input string req);
    int t;
    t = 0;
    while ((exp_q.size() > 0 || cmp_on) && t < 6000) begin
      @(posedge clk); t++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete(); cmp_on = 0;
  endtask

  task automatic check_ones(input int n, input string req);
    bit b;
    for (int i = 0; i < n; i++) begin
      get_bit(b);
      chk(b == 1'b1, req, int'(b), 1);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog", 0, 1);
    if (!done) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] fr[$];
    cyc(3); rst_n = 1'b1; cyc(2);
    // reset state
    chk(wr_ok == 1'b1, "R1 reset wr_ok", int'(wr_ok), 1);
    chk(ovf == 1'b0, "R2 reset ovf", int'(ovf), 0);
    chk(urun == 1'b0, "R7 reset urun", int'(urun), 0);
    chk(txd == 1'b1, "R6 reset line", int'(txd), 1);

    // R9: strobe follows tick by one cycle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(txd_stb == !tick, "R9 strobe", int'(txd_stb), int'(!tick));
    end

    // R6 idle fill with ones
    check_ones(12, "R6 idle ones");

    // frame with stuffing-heavy bytes
    cur_tag = "R3 R4 R5 frame A";
    fr = '{8'h12, 8'hFF, 8'h7E};
    foreach (fr[k]) wr(fr[k]);
    push_frame(fr, 1'b1);
    pulse_end(); pulse_start();
    wait_frame("R5 frame A complete");
    check_ones(10, "R10 single frame per start");
    chk(urun == 1'b0, "R7 no underrun", int'(urun), 0);

    cur_tag = "R4 R5 frame B";
    fr = '{8'hF8, 8'h1F, 8'h00, 8'hA5};
    foreach (fr[k]) wr(fr[k]);
    push_frame(fr, 1'b1);
    pulse_end(); pulse_start();
    wait_frame("R5 frame B complete");

    // R7 underrun
    cur_tag = "R7 underrun frame";
    fr = '{8'h3C, 8'h11};
    foreach (fr[k]) wr(fr[k]);
    push_frame(fr, 1'b0);
    pulse_start();
    wait_frame("R7 abort complete");
    cyc(2);
    chk(urun == 1'b1, "R7 urun set", int'(urun), 1);
    check_ones(8, "R7 fill after abort");
    chk(urun == 1'b1, "R7 urun sticky", int'(urun), 1);
    @(posedge clk); #1; cmd_rst = 1'b1; cyc(2); cmd_rst = 1'b0; cyc(1);
    chk(urun == 1'b0, "R8 reset clears urun", int'(urun), 0);

    // R1/R2 overflow and discarded 33rd byte
    fr.delete();
    for (int i = 0; i < 32; i++) begin
      fr.push_back(8'(i * 7 + 1));
      wr(8'(i * 7 + 1));
    end
    chk(wr_ok == 1'b0, "R1 full clears wr_ok", int'(wr_ok), 0);
    chk(ovf == 1'b0, "R2 no ovf at 32", int'(ovf), 0);
    wr(8'hAA);
    chk(ovf == 1'b1, "R2 ovf on 33rd", int'(ovf), 1);
    cur_tag = "R2 dropped byte frame";
    push_frame(fr, 1'b1);
    pulse_end(); pulse_start();
    wait_frame("R2 frame of 32");
    chk(ovf == 1'b1, "R2 ovf sticky", int'(ovf), 1);
    chk(wr_ok == 1'b1, "R1 wr_ok after drain", int'(wr_ok), 1);
    @(posedge clk); #1; cmd_rst = 1'b1; cyc(1); cmd_rst = 1'b0; cyc(1);
    chk(ovf == 1'b0, "R2 reset clears ovf", int'(ovf), 0);

    // R8 reset mid-frame colliding with a write
    for (int i = 0; i < 4; i++) wr(8'h00);
    pulse_end(); pulse_start();
    cyc(40);
    cmd_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h5A;
    cyc(1); wr_en = 1'b0; cyc(2); cmd_rst = 1'b0;
    check_ones(9, "R8 abort ones");
    chk(wr_ok == 1'b1, "R8 fifo flushed", int'(wr_ok), 1);
    chk(urun == 1'b0 && ovf == 1'b0, "R8 flags clear", int'({urun, ovf}), 0);
    cur_tag = "R8 empty frame after flush";
    fr.delete();
    push_frame(fr, 1'b1);
    pulse_end(); pulse_start();
    wait_frame("R8 empty frame");

    // R6 flag fill
    begin
      bit w[24];
      int ones;
      @(posedge clk); #1; fill_flags = 1'b1;
      for (int i = 0; i < 12; i++) get_bit(w[0]);
      for (int i = 0; i < 24; i++) get_bit(w[i]);
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(w[i]);
      chk(ones == 6, "R6 flag fill ones per byte", ones, 6);
      for (int i = 0; i < 16; i++)
        chk(w[i] == w[i+8], "R6 flag fill period", int'(w[i+8]), int'(w[i]));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule